// File: doc/BRIEF.md
# Configuration Manager Register Block

This block is the register-facing slave of a device configuration manager. A host reads and writes 32-bit words over a simple strobe-based bus. The block holds the configuration mode, the pin-control settings and a DCLK pulse generator. It also shows the live state of the configuration pins and sticky change flags for those pins.

Writing a count to the DCLK count word sends that many DCLK pulses. Each pulse is high for one system clock and low for one system clock. When the last pulse ends, a sticky done flag is set. The host clears that flag by writing one to it.

The pin monitor word mirrors twelve monitored pin and status inputs. Any change on one of those inputs sets a matching pending bit. The host clears pending bits through a write-only acknowledge word.

Top module: `cfg_mgr_regs`

## Requirements
- R1: After reset, the status word (offset 0x0) reads 0x45 when the mode-select inputs are 5'h08, the control word (offset 0x4) reads 0x200, `ctrl_o` is 0x200 and `irq_pend_o` is 0.
- R2: Status bits [2:0] hold the mode and can be read and written. The reset value is 5 and the encodings run 0 to 5 (power-off, reset, configuration, initialization, user, undefined). Bits [7:3] always show `msel_i`. Writes to bits [31:3] are ignored and bits [31:8] read 0.
- R3: The control word keeps bits [9:0] as written and reads 0 in bits [31:10]. Its bits drive `ctrl_o[9:0]` directly: bit 0 enable, bit 1 chip enable (active low), bit 2 nCONFIG pull, bit 3 nSTATUS pull, bit 4 CONF_DONE pull, bit 5 partial reconfiguration request, bits [7:6] clock-to-data ratio, bit 8 bus data enable, bit 9 width.
- R4: `ncfg_n_o` is 0 exactly when control bits 0 and 2 are both 1. Otherwise it is 1.
- R5: Writing N to offset 0x8 sends exactly N pulses on `dclk_o`. Each pulse is high for one clock and low for one clock. Reading 0x8 returns the number of pulses still to send. Writing 0 sends no pulses and leaves the done flag unchanged.
- R6: Bit 0 of offset 0xC becomes 1 after the last pulse of a count and stays 1. Writing 1 to it clears it. Writing 0 to it has no effect.
- R7: A count written while pulses are still being sent discards the remaining pulses. Exactly the new number of pulses then follows.
- R8: Offset 0x850 reads {`power_ok_i`, `pin_sense_i[2:0]`, `cfg_flags_i[7:0]`} in bits [11:0] and 0 above. Writes to it are ignored.
- R9: Any change on a monitored input sets the matching bit of `irq_pend_o`. Writing 1 to a bit at offset 0x84C clears that pending bit. A change in the same cycle wins over the clear. Offset 0x84C reads 0.
- R10: Unmapped offsets read 0, and writes to them change no register.
- R11: A read strobe returns `rdata_o` together with a one-cycle `rvalid_o` pulse on the next clock. Without a read strobe, `rvalid_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| rvalid_o | output | 1 | Read data valid |
| msel_i | input | 5 | Mode-select pin value |
| cfg_flags_i | input | 8 | Status flags for monitor bits [7:0] |
| pin_sense_i | input | 3 | Pin levels for monitor bits [10:8] |
| power_ok_i | input | 1 | Power-on indication, monitor bit 11 |
| ctrl_o | output | 10 | Control word fields |
| ncfg_n_o | output | 1 | nCONFIG drive, active low |
| dclk_o | output | 1 | DCLK pulse output |
| irq_pend_o | output | 12 | Pending change flags |

## Verification
The bench builds the block with its default parameters: a 12-bit offset and a 16-bit DCLK counter. With these values every mapped word is reachable, including the high monitor offsets. Short counts of 0, 3, 5 and 3 cover the empty count, a plain burst and a restart in mid-burst within a few dozen cycles. Pulse edges and high cycles are counted on the pin, so the test can show both the number of pulses and the one-high, one-low shape of each pulse.

// File: rtl/cfg_mgr_regs.sv
module cfg_mgr_regs #(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              rvalid_o,
  input  logic [4:0]        msel_i,
  input  logic [7:0]        cfg_flags_i,
  input  logic [2:0]        pin_sense_i,
  input  logic              power_ok_i,
  output logic [9:0]        ctrl_o,
  output logic              ncfg_n_o,
  output logic              dclk_o,
  output logic [11:0]       irq_pend_o
);
  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'('h000);
  localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'('h004);
  localparam logic [ADDR_W-1:0] OFF_CNT  = ADDR_W'('h008);
  localparam logic [ADDR_W-1:0] OFF_DST  = ADDR_W'('h00C);
  localparam logic [ADDR_W-1:0] OFF_ACK  = ADDR_W'('h84C);
  localparam logic [ADDR_W-1:0] OFF_MON  = ADDR_W'('h850);
  localparam int MON_W = 12;

  logic [2:0]       mode_q;
  logic [9:0]       ctrl_q;
  logic [CNT_W-1:0] rem_q;
  logic             dclk_q, done_q;
  logic [MON_W-1:0] mon_q, pend_q;
  logic [31:0]      rd_mux;

  wire [MON_W-1:0] mon_w = {power_ok_i, pin_sense_i, cfg_flags_i};
  wire wr_stat = wr_en_i && addr_i == OFF_STAT;
  wire wr_ctrl = wr_en_i && addr_i == OFF_CTRL;
  wire wr_cnt  = wr_en_i && addr_i == OFF_CNT;
  wire wr_dst  = wr_en_i && addr_i == OFF_DST;
  wire wr_ack  = wr_en_i && addr_i == OFF_ACK;
  wire last_fall = dclk_q && rem_q == CNT_W'(1);

  assign ctrl_o     = ctrl_q;
  assign ncfg_n_o   = ~(ctrl_q[0] & ctrl_q[2]);
  assign dclk_o     = dclk_q;
  assign irq_pend_o = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 3'd5;
      ctrl_q <= 10'h200;
    end else begin
      if (wr_stat) mode_q <= wdata_i[2:0];
      if (wr_ctrl) ctrl_q <= wdata_i[9:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      dclk_q <= 1'b0;
    end else if (wr_cnt) begin
      rem_q  <= wdata_i[CNT_W-1:0];
      dclk_q <= 1'b0;
    end else if (rem_q != '0) begin
      dclk_q <= ~dclk_q;
      if (dclk_q) rem_q <= rem_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     done_q <= 1'b0;
    else if (last_fall && !wr_cnt)  done_q <= 1'b1;
    else if (wr_dst && wdata_i[0])  done_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mon_q  <= '0;
      pend_q <= '0;
    end else begin
      mon_q  <= mon_w;
      pend_q <= (pend_q & ~(wr_ack ? wdata_i[MON_W-1:0] : '0)) | (mon_w ^ mon_q);
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      OFF_STAT: rd_mux = {24'd0, msel_i, mode_q};
      OFF_CTRL: rd_mux = {22'd0, ctrl_q};
      OFF_CNT:  rd_mux = 32'(rem_q);
      OFF_DST:  rd_mux = {31'd0, done_q};
      OFF_MON:  rd_mux = 32'(mon_w);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rdata_o  <= rd_en_i ? rd_mux : '0;
      rvalid_o <= rd_en_i;
    end
  end
endmodule

// File: rtl/cfg_mgr_regs_chk.sv
module cfg_mgr_regs_chk #(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic              rvalid,
  input logic [9:0]        ctrl,
  input logic              dclk,
  input logic [11:0]       pend,
  input logic [CNT_W-1:0]  rem,
  input logic              done
);
  assert_pulse_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dclk |=> !dclk);
  assert_pulse_needs_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dclk |-> rem != '0);
  assert_done_after_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(dclk));
  assert_read_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid);
  assert_no_spurious_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rvalid);
  assert_ctrl_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == ADDR_W'('h004)) |=> $stable(ctrl));
  assert_pend_clear_by_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~$past(pend)) == '0 && $past(pend) != pend) |-> $past(wr_en && addr == ADDR_W'('h84C)));
endmodule

bind cfg_mgr_regs cfg_mgr_regs_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .rd_en(rd_en_i), .addr(addr_i),
  .rvalid(rvalid_o), .ctrl(ctrl_o), .dclk(dclk_o), .pend(irq_pend_o),
  .rem(rem_q), .done(done_q)
);

// File: tb/cfg_mgr_regs_tb.sv
module cfg_mgr_regs_tb;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0;
  logic [11:0] addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic rvalid;
  logic [4:0] msel = 5'h08;
  logic [7:0] flags = 0;
  logic [2:0] sense = 0;
  logic pwr = 0;
  logic [9:0] ctrl;
  logic ncfg_n, dclk;
  logic [11:0] pend;

  int n_run = 0, n_fail = 0;
  int pulses = 0, highs = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  cfg_mgr_regs u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid), .msel_i(msel),
    .cfg_flags_i(flags), .pin_sense_i(sense), .power_ok_i(pwr), .ctrl_o(ctrl),
    .ncfg_n_o(ncfg_n), .dclk_o(dclk), .irq_pend_o(pend)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); rd_en = 1; addr = a; exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); rd_en = 0;
  endtask

  always @(negedge clk) begin
    if (rvalid) begin
      if (exp_q.size() == 0) check(0, "R11 unexpected rvalid", 1, 0);
      else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rdata == e, t, rdata, e);
      end
    end
    if (dclk) highs++;
  end

  always @(posedge dclk) pulses++;

  initial begin
    #2_000_000;
    check(0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(ctrl == 10'h200, "R1 ctrl_o reset", 32'(ctrl), 32'h200);
    check(pend == 0, "R1 pending reset", 32'(pend), 0);
    rd(12'h000, 32'h45, "R1 status reset");
    rd(12'h004, 32'h200, "R1 control reset");

    wr(12'h000, 32'hFFFF_FF02);
    rd(12'h000, 32'h42, "R2 mode write, upper ignored");
    msel = 5'h0A;
    rd(12'h000, 32'h52, "R2 msel reflected");

    wr(12'h004, 32'hFFFF_FC05);
    rd(12'h004, 32'h005, "R3 control masked");
    check(ctrl == 10'h005, "R3 ctrl_o", 32'(ctrl), 32'h005);
    check(ncfg_n == 0, "R4 ncfg asserted", 32'(ncfg_n), 0);
    wr(12'h004, 32'h001);
    check(ncfg_n == 1, "R4 enable only", 32'(ncfg_n), 1);
    wr(12'h004, 32'h004);
    check(ncfg_n == 1, "R4 pull only", 32'(ncfg_n), 1);

    pulses = 0; highs = 0;
    wr(12'h008, 32'd3);
    rd(12'h008, 32'd3, "R5 remaining after write");
    repeat (20) @(negedge clk);
    check(pulses == 3, "R5 pulse count", 32'(pulses), 3);
    check(highs == 3, "R5 high cycles", 32'(highs), 3);
    rd(12'h008, 32'd0, "R5 remaining drained");
    rd(12'h00C, 32'd1, "R6 done set");
    wr(12'h00C, 32'd0);
    rd(12'h00C, 32'd1, "R6 write zero keeps done");
    wr(12'h00C, 32'd1);
    rd(12'h00C, 32'd0, "R6 write one clears");

    pulses = 0;
    wr(12'h008, 32'd0);
    repeat (10) @(negedge clk);
    check(pulses == 0, "R5 zero count no pulses", 32'(pulses), 0);
    rd(12'h00C, 32'd0, "R5 zero count keeps done clear");

    pulses = 0;
    wr(12'h008, 32'd5);
    repeat (3) @(negedge clk);
    wr(12'h008, 32'd3);
    repeat (20) @(negedge clk);
    check(pulses == 5, "R7 restart total pulses", 32'(pulses), 5);
    rd(12'h00C, 32'd1, "R7 done after restart");
    wr(12'h00C, 32'd1);

    @(negedge clk); flags = 8'hA5; sense = 3'b101; pwr = 1;
    repeat (2) @(negedge clk);
    rd(12'h850, 32'hDA5, "R8 monitor bits");
    wr(12'h850, 32'h0);
    rd(12'h850, 32'hDA5, "R8 monitor write ignored");
    check(pend == 12'hDA5, "R9 pending set on change", 32'(pend), 32'hDA5);
    wr(12'h84C, 32'h0A5);
    check(pend == 12'hD00, "R9 ack clears selected", 32'(pend), 32'hD00);
    rd(12'h84C, 32'h0, "R9 ack reads zero");
    @(negedge clk); flags = 8'hA4;
    @(negedge clk);
    check(pend == 12'hD01, "R9 change after ack", 32'(pend), 32'hD01);

    rd(12'h010, 32'h0, "R10 unmapped read");
    wr(12'h010, 32'hFFFF_FFFF);
    rd(12'h004, 32'h004, "R10 control untouched");
    rd(12'h000, 32'h52, "R10 status untouched");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R11 all reads answered", 32'(exp_q.size()), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule